// File: doc/BRIEF.md
# Gated Carrier Generator

The block produces a modulated carrier for an infrared-style transmitter. An 8-bit carrier timer advances on a count-clock tick input and alternates between a high phase and a low phase. Each phase length is set by its own compare register. A gate bit decides whether the carrier reaches the pin. Software writes that gate bit into a buffer. A pulse on the envelope input, which comes from a separate envelope timer outside this block, copies the buffer into the active gate. Burst edges therefore line up with envelope events and not with software writes.

The low-phase compare does not act at once. A write to it is staged, and it reaches the comparator on the third count-clock tick after the write. Stopping the timer discards that compare value, so each restart needs a fresh write. A mode bit is captured while the timer is stopped. With the mode bit set, the pin carries the carrier ANDed with the active gate. With it clear, the pin carries the active gate as a plain level. A one-cycle interrupt marks the end of every carrier period.

Registers are written through a simple port. At address 0 (control), bit 0 is run and bit 1 is the mode bit. Address 1 holds the high-phase compare. Address 2 holds the low-phase compare. At address 3, bit 0 is the buffered gate.

Top module: `carrier_gate_gen`

## Requirements
- R1: After reset, `pin_out` and `period_irq` are 0, the timer is stopped, the mode is plain level, and the active and buffered gates are 0.
- R2: A write of 0x00 to either compare register (address 1 or 2) is ignored, and the previous value stays in force.
- R3: A low-phase compare written to address 2 takes effect on the third `cnt_tick` after the write cycle. The high-phase compare at address 1 takes effect at once.
- R4: While running with a valid low compare, the carrier starts high in the cycle after run is set. It then stays high for (high compare + 1) ticks and low for (low compare + 1) ticks, alternating.
- R5: Clearing run (a write of bit 0 = 0 to address 0) discards the active low compare. After a restart the carrier stays low until address 2 is written again and the transfer of R3 completes.
- R6: An `env_evt` pulse copies the buffered gate into the active gate. If a gate write and `env_evt` fall in the same cycle, the old buffered value is copied.
- R7: The mode bit (address 0, bit 1) is captured only by control writes made while stopped. A control write made while running leaves the mode unchanged.
- R8: With mode 1, `pin_out` = carrier AND active gate. With mode 0, `pin_out` = active gate as a level, whatever the carrier is doing.
- R9: `period_irq` pulses for one cycle in each cycle where the carrier returns high at the end of a low phase. It does not pulse at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cnt_tick | input | 1 | Carrier count-clock enable, one cycle per tick |
| env_evt | input | 1 | Envelope timer event, one-cycle pulse |
| pin_out | output | 1 | Gated carrier or gate level |
| period_irq | output | 1 | Carrier period-end interrupt |

## Verification
The assertions assume three things about the inputs. `env_evt` is a single-cycle pulse. Gate writes are spaced at least two cycles apart. The carrier tick runs well faster than the envelope events, so every envelope pulse sees a settled buffered gate. The bench keeps to these assumptions: it drives each envelope pulse and each gate write from its own task, leaves idle cycles between them, and varies the tick rate only between one tick per cycle and one tick every two cycles. The one deliberate same-cycle gate write and envelope pulse is the R6 corner, and its outcome is fixed.

// File: rtl/cgg_pkg.sv
package cgg_pkg;
  localparam int unsigned CMP_W = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_HI   = 2'd1,
    A_LO   = 2'd2,
    A_GATE = 2'd3
  } cgg_addr_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;

  function automatic logic cmp_ok(input logic [CMP_W-1:0] v);
    return v != '0;
  endfunction

  function automatic logic phase_done(input logic [CMP_W-1:0] cnt,
                                      input logic [CMP_W-1:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/cgg_regs.sv
module cgg_regs
  import cgg_pkg::*;
#(
  parameter int unsigned XFER_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CMP_W-1:0] wr_data,
  input  logic             cnt_tick,
  output logic             run,
  output logic             mode_act,
  output logic [CMP_W-1:0] hi_cmp,
  output logic [CMP_W-1:0] lo_act,
  output logic             lo_valid,
  output logic             gate_buf,
  output logic             lo_wr,
  output logic             lo_xfer
);
  localparam int unsigned PC_W = $clog2(XFER_TICKS + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(XFER_TICKS - 1);

  logic             run_q, mode_q, valid_q, pend_q, gate_q;
  logic [CMP_W-1:0] hi_q, lo_stage_q, lo_act_q;
  logic [PC_W-1:0]  pcnt_q;
  logic             ctrl_wr, hi_wr, stop_ev;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign hi_wr   = wr_en && (wr_addr == A_HI) && cmp_ok(wr_data);
  assign lo_wr   = wr_en && (wr_addr == A_LO) && cmp_ok(wr_data);
  assign stop_ev = ctrl_wr && run_q && !wr_data[CTRL_RUN_BIT];
  assign lo_xfer = pend_q && cnt_tick && (pcnt_q == PC_LAST) && !lo_wr && !stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      gate_q <= 1'b0;
      hi_q   <= CMP_W'(1);
    end else begin
      if (ctrl_wr) begin
        run_q <= wr_data[CTRL_RUN_BIT];
        if (!run_q) mode_q <= wr_data[CTRL_MODE_BIT];
      end
      if (hi_wr) hi_q <= wr_data;
      if (wr_en && wr_addr == A_GATE) gate_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage_q <= CMP_W'(1);
      lo_act_q   <= CMP_W'(1);
      pend_q     <= 1'b0;
      pcnt_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      if (lo_wr) begin
        lo_stage_q <= wr_data;
        pend_q     <= 1'b1;
        pcnt_q     <= '0;
      end else if (stop_ev || lo_xfer) begin
        pend_q <= 1'b0;
        pcnt_q <= '0;
      end else if (pend_q && cnt_tick) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
      if (lo_xfer) lo_act_q <= lo_stage_q;
      if (stop_ev)      valid_q <= 1'b0;
      else if (lo_xfer) valid_q <= 1'b1;
    end
  end

  assign run      = run_q;
  assign mode_act = mode_q;
  assign hi_cmp   = hi_q;
  assign lo_act   = lo_act_q;
  assign lo_valid = valid_q;
  assign gate_buf = gate_q;
endmodule

// File: rtl/cgg_carrier.sv
module cgg_carrier
  import cgg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cnt_tick,
  input  logic [CMP_W-1:0] hi_cmp,
  input  logic [CMP_W-1:0] lo_cmp,
  output logic             carrier,
  output logic             wrap_irq
);
  logic [CMP_W-1:0] cnt_q;
  logic             phase_hi_q, irq_q, hi_end, lo_end;

  assign hi_end = phase_hi_q && phase_done(cnt_q, hi_cmp);
  assign lo_end = !phase_hi_q && phase_done(cnt_q, lo_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      phase_hi_q <= 1'b1;
      irq_q      <= 1'b0;
    end else if (!en) begin
      cnt_q      <= '0;
      phase_hi_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= cnt_tick && lo_end;
      if (cnt_tick) begin
        if (hi_end || lo_end) begin
          cnt_q      <= '0;
          phase_hi_q <= !phase_hi_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign carrier  = en && phase_hi_q;
  assign wrap_irq = en && irq_q;
endmodule

// File: rtl/cgg_gate.sv
module cgg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic env_evt,
  input  logic gate_buf,
  output logic gate_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_act <= 1'b0;
    else if (env_evt) gate_act <= gate_buf;
  end
endmodule

// File: rtl/carrier_gate_gen.sv
module carrier_gate_gen
  import cgg_pkg::*;
#(
  parameter int unsigned XFER_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CMP_W-1:0] wr_data,
  input  logic             cnt_tick,
  input  logic             env_evt,
  output logic             pin_out,
  output logic             period_irq
);
  logic             run, mode_act, lo_valid, gate_buf, gate_act;
  logic             lo_wr, lo_xfer, carrier, car_en;
  logic [CMP_W-1:0] hi_cmp, lo_act;

  cgg_regs #(.XFER_TICKS(XFER_TICKS)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cnt_tick,
    .run, .mode_act, .hi_cmp, .lo_act, .lo_valid, .gate_buf,
    .lo_wr, .lo_xfer
  );

  assign car_en = run && lo_valid;

  cgg_carrier u_car (
    .clk, .rst_n, .en(car_en), .cnt_tick,
    .hi_cmp, .lo_cmp(lo_act), .carrier, .wrap_irq(period_irq)
  );

  cgg_gate u_gate (.clk, .rst_n, .env_evt, .gate_buf, .gate_act);

  assign pin_out = mode_act ? (carrier && gate_act) : gate_act;
endmodule

// File: rtl/cgg_checker.sv
module cgg_checker #(
  parameter int unsigned XFER_TICKS = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_tick,
  input logic       env_evt,
  input logic       run,
  input logic       mode_act,
  input logic       lo_wr,
  input logic       lo_xfer,
  input logic       lo_valid,
  input logic [7:0] lo_act,
  input logic [7:0] hi_cmp,
  input logic       gate_buf,
  input logic       gate_act,
  input logic       carrier,
  input logic       period_irq
);
  int unsigned tks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tks <= 0;
    else if (lo_wr)                    tks <= 0;
    else if (cnt_tick && tks < 1000)   tks <= tks + 1;
  end

  p_xfer_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_xfer |-> (cnt_tick && tks == XFER_TICKS - 1));
  p_cmp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cmp != 8'd0) && (lo_act != 8'd0));
  p_stop_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !lo_valid);
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_valid |-> !carrier);
  p_gate_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    env_evt |=> (gate_act == $past(gate_buf)));
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !env_evt |=> $stable(gate_act));
  p_mode_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(mode_act));
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (carrier && !$past(carrier)));
endmodule

bind carrier_gate_gen cgg_checker #(.XFER_TICKS(XFER_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .env_evt(env_evt),
  .run(run), .mode_act(mode_act), .lo_wr(lo_wr), .lo_xfer(lo_xfer),
  .lo_valid(lo_valid), .lo_act(lo_act), .hi_cmp(hi_cmp),
  .gate_buf(gate_buf), .gate_act(gate_act), .carrier(carrier),
  .period_irq(period_irq)
);

// File: tb/carrier_gate_gen_bench.sv
module carrier_gate_gen_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       cnt_tick = 1'b1;
  logic       env_evt = 1'b0;
  logic       pin_out, period_irq;
  int         tick_div = 1;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  carrier_gate_gen u_carrier_gate_gen (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cnt_tick, .env_evt,
    .pin_out, .period_irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      if (tick_div <= 1) cnt_tick = 1'b1;
      else begin
        cnt_tick = (tc == 0);
        tc = (tc + 1) % tick_div;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic env_pulse();
    @(negedge clk);
    env_evt = 1'b1;
    @(negedge clk);
    env_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hold_level(input string req, input int lvl, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out !== lvl[0]) bad++;
    end
    chk(req, bad, 0);
  endtask

  // Full segments after the first edge must match; irq must equal each rise.
  task automatic measure(input string req, input int hi_len, input int lo_len, input int n);
    logic prev = pin_out;
    int len = 0, segs = 0, bad_len = 0, bad_irq = 0;
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (period_irq !== (pin_out && !prev)) bad_irq++;
      if (pin_out == prev) len++;
      else begin
        if (seen) begin
          segs++;
          if (len != (prev ? hi_len : lo_len)) bad_len++;
        end
        seen = 1; len = 1; prev = pin_out;
      end
    end
    chk({req, " segment lengths"}, bad_len, 0);
    chk({req, " segment count"}, int'(segs >= 2), 1);
    chk("R9 irq at period end", bad_irq, 0);
  endtask

  task automatic t_reset();
    chk("R1 out", pin_out, 0);
    chk("R1 irq", period_irq, 0);
    hold_level("R1 idle", 0, 5);
  endtask

  task automatic t_gate();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01; env_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; env_evt = 1'b0;
    chk("R6 same-cycle old value", pin_out, 0);
    env_pulse();
    chk("R6 copy on event", pin_out, 1);
    wr(2'd3, 8'h00);
    idle(2);
    chk("R6 buffer only", pin_out, 1);
    env_pulse();
    chk("R8 plain level follows gate", pin_out, 0);
  endtask

  task automatic t_basic();
    wr(2'd0, 8'h02);
    wr(2'd3, 8'h01); env_pulse();
    chk("R8 mode1 stopped", pin_out, 0);
    wr(2'd1, 8'd3); wr(2'd2, 8'd5);
    idle(6);
    wr(2'd0, 8'h03);
    chk("R4 starts high", pin_out, 1);
    chk("R9 no irq at start", period_irq, 0);
    measure("R4 fast tick", 4, 6, 60);
  endtask

  task automatic t_slow();
    tick_div = 2;
    idle(2);
    measure("R4 slow tick", 8, 12, 100);
    tick_div = 1;
    idle(2);
  endtask

  task automatic t_mode_lock();
    wr(2'd0, 8'h01);
    measure("R7 mode ignored while running", 4, 6, 60);
  endtask

  task automatic t_gate_off();
    wr(2'd3, 8'h00); env_pulse();
    hold_level("R8 gate off masks carrier", 0, 20);
    wr(2'd3, 8'h01); env_pulse();
  endtask

  task automatic t_restart();
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h03);
    hold_level("R5 held after restart", 0, 12);
    wr(2'd2, 8'h00);
    hold_level("R2 zero low compare ignored", 0, 12);
    wr(2'd2, 8'd4);
    @(negedge clk); chk("R3 not after 1 tick", pin_out, 0);
    @(negedge clk); chk("R3 not after 2 ticks", pin_out, 0);
    @(negedge clk); chk("R3 after 3 ticks", pin_out, 1);
    measure("R3 new low compare", 4, 5, 60);
  endtask

  task automatic t_hi_cmp();
    wr(2'd1, 8'h00);
    measure("R2 zero high compare ignored", 4, 5, 60);
    wr(2'd1, 8'd6);
    measure("R3 high compare immediate", 7, 5, 60);
  endtask

  task automatic t_plain();
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd2);
    idle(5);
    wr(2'd0, 8'h01);
    hold_level("R8 plain level while running", 1, 20);
    wr(2'd3, 8'h00); env_pulse();
    hold_level("R8 plain level gate off", 0, 10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_gate();
    t_basic();
    t_slow();
    t_mode_lock();
    t_gate_off();
    t_restart();
    t_hi_cmp();
    t_plain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule